// File: doc/BRIEF.md
# FPGA Configuration Sequencer

This block steps an attached FPGA fabric through a passive-parallel load. When a start pulse is accepted, it turns the 4-bit mode-select code into a data-bus width and a clock-to-data ratio. It then resets the fabric by pulling its configuration-reset line and waits for the fabric to report the reset phase and then the configuration phase. It clears the fabric's status event and opens the data path for the external packer, which streams the image. Once the packer reports the end of the image, the block watches the done and status flags from the fabric until the two agree. It then closes the data path, asks an external clock counter for trailing DCLKs and waits for user mode.

Every wait is polled once per clock and has its own timeout. The final outcome is held on `status` and is marked by a one-cycle `done` pulse. A fault seen during the data phase is reported even if a later phase also fails.

States: `S_IDLE` (accept start, or refuse it and go to `S_FINISH`), `S_SETUP` (latch width and ratio, drive chip enable low), `S_PULL` (pull the reset line and wait for the reset phase, or time out), `S_RELEASE` (release the line, then report a pending timeout or go on), `S_WAIT_CFG` (wait for the configuration phase), `S_CLR_NS` (one-cycle event clear), `S_DATA` (path open, wait for end of image or a stream fault), `S_CHECK` (wait for the flags to settle, or a CRC fault, or a timeout), `S_DATA_OFF` (close the path, load the DCLK count), `S_WAIT_DCLK` (wait for the counter), `S_WAIT_USER` (wait for user mode), `S_FINISH` (`done` pulse, back to `S_IDLE`).

Top module: `fpga_cfg_seq`

## Requirements
- R1: Mode codes 0, 1, 2, 4, 5 and 6 select the 16-bit bus (`wide_bus`=0). Codes 8, 9, 10, 12, 13 and 14 select the 32-bit bus (`wide_bus`=1). Bit 2 of the code has no effect on width or ratio.
- R2: The two low bits of the code, 0, 1 and 2, give `cd_ratio` 1, 2 and 4 on the 16-bit bus and 1, 4 and 8 on the 32-bit bus.
- R3: Codes 3, 7, 11 and 15 end the run at once with status 6 (bad mode) and never pull the reset line.
- R4: A start with `ctl_en` low ends with status 4, whatever the power state. A start with `ctl_en` high and `fab_pwr_ok` low ends with status 5. Both refusals give `done` on the cycle after the start.
- R5: A run makes these steps in this order: `nce` low, `nconfig_pull` high, `nconfig_pull` low, a one-cycle `nstatus_clr`, then `data_en` high. The reset line and the data path are never active together. Fabric phase codes are 0 for reset, 1 for configuration, 2 for initialisation and 3 for user mode.
- R6: If the reset phase is not seen within 2048 polls, the reset line is released first. Status 3 (timeout) is reported afterwards, with the line already low when `done` is high.
- R7: After the end of the image, `conf_done`=`nstatus`=1 gives status 0 (pass) and both at 0 gives status 1 (configuration failure). Unequal flags keep the block waiting. `crc_err` leaves the check at once with status 2.
- R8: After the check, `data_en` falls and `dclk_load` pulses for one cycle with `dclk_count`=4. The block waits for `dclk_done` and then for phase 3 before it reports.
- R9: The configuration-phase and user-mode waits time out after 2048 polls. The flag check times out after 8192 polls. The DCLK wait times out after 2056 polls. Each timeout gives status 3.
- R10: A data-phase fault (`data_err` gives status 1) takes precedence over a later DCLK or user-mode timeout.
- R11: `busy` is high from the cycle after an accepted start until the final status. `done` is a single-cycle pulse with `busy` low, and `status` changes only when `done` is high.
- R12: A start pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one poll per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in idle |
| ctl_en | input | 1 | Sequencer owns the fabric control lines |
| fab_pwr_ok | input | 1 | Fabric is powered |
| msel | input | 4 | Mode-select code |
| fab_phase | input | 2 | Fabric phase: 0 reset, 1 config, 2 init, 3 user |
| conf_done | input | 1 | Fabric configuration-done flag |
| nstatus | input | 1 | Fabric status flag (low = error) |
| crc_err | input | 1 | Fabric CRC fault flag |
| data_last | input | 1 | Packer: final image word written |
| data_err | input | 1 | Packer: stream fault |
| dclk_done | input | 1 | DCLK counter finished |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 pass, 1 cfg fail, 2 CRC, 3 timeout, 4 no control, 5 power off, 6 bad mode |
| wide_bus | output | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cd_ratio | output | 4 | Clock-to-data ratio (1, 2, 4 or 8) |
| nce | output | 1 | Active-low fabric chip enable |
| nconfig_pull | output | 1 | Hold the fabric configuration-reset line |
| nstatus_clr | output | 1 | Clear the latched status event |
| data_en | output | 1 | Image data path open |
| dclk_load | output | 1 | Load the trailing DCLK count |
| dclk_count | output | 16 | Number of trailing DCLKs |

## Verification
A state register that skips or repeats a step shows up within a cycle or two as a change in the order of `nconfig_pull`, `nstatus_clr`, `data_en` and `dclk_load`. It can also show as a pulse that lasts more than one cycle. A wrong timeout reload shows up only at the end of a wait: `done` arrives too early or too late against 2048, 2056 or 8192 polls. A lost data-phase status shows up at the final `done` as a pass or timeout code in place of the fault code. The decode table is walked over all sixteen codes, so a single wrong entry shows up on `wide_bus`/`cd_ratio` or as a wrong bad-mode refusal.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int MSEL_W  = 4;
    localparam int RATIO_W = 4;
    localparam int STAT_W  = 3;
    localparam int PHASE_W = 2;

    localparam logic [PHASE_W-1:0] PH_RESET  = 2'd0;
    localparam logic [PHASE_W-1:0] PH_CONFIG = 2'd1;
    localparam logic [PHASE_W-1:0] PH_INIT   = 2'd2;
    localparam logic [PHASE_W-1:0] PH_USER   = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_PULL,
        S_RELEASE,
        S_WAIT_CFG,
        S_CLR_NS,
        S_DATA,
        S_CHECK,
        S_DATA_OFF,
        S_WAIT_DCLK,
        S_WAIT_USER,
        S_FINISH
    } seq_state_t;

    typedef enum logic [STAT_W-1:0] {
        ST_OK       = 3'd0,
        ST_CFG_FAIL = 3'd1,
        ST_CRC      = 3'd2,
        ST_TIMEOUT  = 3'd3,
        ST_NO_CTRL  = 3'd4,
        ST_PWR_OFF  = 3'd5,
        ST_BAD_MODE = 3'd6
    } seq_status_t;

endpackage

// File: rtl/fcs_mode_dec.sv
module fcs_mode_dec
    import fcs_pkg::*;
(
    input  logic [MSEL_W-1:0]  msel,
    output logic               mode_ok,
    output logic               wide,
    output logic [RATIO_W-1:0] ratio
);

    // Bit 2 (fast/slow) does not change width or ratio.
    always_comb begin
        mode_ok = 1'b1;
        wide    = 1'b0;
        ratio   = RATIO_W'(1);
        unique case (msel)
            4'd0, 4'd4:   begin wide = 1'b0; ratio = RATIO_W'(1); end
            4'd1, 4'd5:   begin wide = 1'b0; ratio = RATIO_W'(2); end
            4'd2, 4'd6:   begin wide = 1'b0; ratio = RATIO_W'(4); end
            4'd8, 4'd12:  begin wide = 1'b1; ratio = RATIO_W'(1); end
            4'd9, 4'd13:  begin wide = 1'b1; ratio = RATIO_W'(4); end
            4'd10, 4'd14: begin wide = 1'b1; ratio = RATIO_W'(8); end
            default:      begin mode_ok = 1'b0; end
        endcase
    end

endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
    import fcs_pkg::*;
#(
    parameter int STATE_POLLS = 2048,
    parameter int CHECK_POLLS = 8192,
    parameter int TRAIL_DCLKS = 4,
    parameter int DCLK_SLACK  = 2048,
    parameter int DCLK_MUL    = 2,
    parameter int DCLK_W      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 ctl_en,
    input  logic                 fab_pwr_ok,
    input  logic [3:0]           msel,
    input  logic [1:0]           fab_phase,
    input  logic                 conf_done,
    input  logic                 nstatus,
    input  logic                 crc_err,
    input  logic                 data_last,
    input  logic                 data_err,
    input  logic                 dclk_done,
    output logic                 busy,
    output logic                 done,
    output logic [2:0]           status,
    output logic                 wide_bus,
    output logic [3:0]           cd_ratio,
    output logic                 nce,
    output logic                 nconfig_pull,
    output logic                 nstatus_clr,
    output logic                 data_en,
    output logic                 dclk_load,
    output logic [DCLK_W-1:0]    dclk_count
);

    localparam int DCLK_POLLS = DCLK_SLACK + TRAIL_DCLKS * DCLK_MUL;
    localparam int MAX_A      = (STATE_POLLS > CHECK_POLLS) ? STATE_POLLS : CHECK_POLLS;
    localparam int MAX_POLLS  = (MAX_A > DCLK_POLLS) ? MAX_A : DCLK_POLLS;
    localparam int CNT_W      = $clog2(MAX_POLLS + 1);

    seq_state_t  state_q, state_n;
    seq_status_t fin_q, fin_n;
    seq_status_t dstat_q, dstat_n;
    logic        rst_to_q, rst_to_n;
    logic        latch_mode;
    logic        wide_q;
    logic [RATIO_W-1:0] ratio_q;

    logic               dec_ok, dec_wide;
    logic [RATIO_W-1:0] dec_ratio;
    logic               tmr_load, tmr_expired;
    logic [CNT_W-1:0]   tmr_val;

    fcs_mode_dec u_dec (
        .msel    (msel),
        .mode_ok (dec_ok),
        .wide    (dec_wide),
        .ratio   (dec_ratio)
    );

    fcs_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Later-phase timeout: data-phase fault wins over the timeout code.
    function automatic seq_status_t late_fail(input seq_status_t ds);
        return (ds != ST_OK) ? ds : ST_TIMEOUT;
    endfunction

    // Next-state and result decisions
    always_comb begin
        state_n    = state_q;
        fin_n      = fin_q;
        dstat_n    = dstat_q;
        rst_to_n   = rst_to_q;
        latch_mode = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (!ctl_en) begin
                        fin_n   = ST_NO_CTRL;
                        state_n = S_FINISH;
                    end else if (!fab_pwr_ok) begin
                        fin_n   = ST_PWR_OFF;
                        state_n = S_FINISH;
                    end else if (!dec_ok) begin
                        fin_n   = ST_BAD_MODE;
                        state_n = S_FINISH;
                    end else begin
                        latch_mode = 1'b1;
                        dstat_n    = ST_OK;
                        rst_to_n   = 1'b0;
                        state_n    = S_SETUP;
                    end
                end
            end
            S_SETUP: state_n = S_PULL;
            S_PULL: begin
                if (fab_phase == PH_RESET) begin
                    state_n = S_RELEASE;
                end else if (tmr_expired) begin
                    rst_to_n = 1'b1;
                    state_n  = S_RELEASE;
                end
            end
            S_RELEASE: begin
                if (rst_to_q) begin
                    fin_n   = ST_TIMEOUT;
                    state_n = S_FINISH;
                end else begin
                    state_n = S_WAIT_CFG;
                end
            end
            S_WAIT_CFG: begin
                if (fab_phase == PH_CONFIG) begin
                    state_n = S_CLR_NS;
                end else if (tmr_expired) begin
                    fin_n   = ST_TIMEOUT;
                    state_n = S_FINISH;
                end
            end
            S_CLR_NS: state_n = S_DATA;
            S_DATA: begin
                if (data_err) begin
                    dstat_n = ST_CFG_FAIL;
                    state_n = S_DATA_OFF;
                end else if (data_last) begin
                    state_n = S_CHECK;
                end
            end
            S_CHECK: begin
                if (crc_err) begin
                    dstat_n = ST_CRC;
                    state_n = S_DATA_OFF;
                end else if (conf_done == nstatus) begin
                    dstat_n = conf_done ? ST_OK : ST_CFG_FAIL;
                    state_n = S_DATA_OFF;
                end else if (tmr_expired) begin
                    dstat_n = ST_TIMEOUT;
                    state_n = S_DATA_OFF;
                end
            end
            S_DATA_OFF: state_n = S_WAIT_DCLK;
            S_WAIT_DCLK: begin
                if (dclk_done) begin
                    state_n = S_WAIT_USER;
                end else if (tmr_expired) begin
                    fin_n   = late_fail(dstat_q);
                    state_n = S_FINISH;
                end
            end
            S_WAIT_USER: begin
                if (fab_phase == PH_USER) begin
                    fin_n   = dstat_q;
                    state_n = S_FINISH;
                end else if (tmr_expired) begin
                    fin_n   = late_fail(dstat_q);
                    state_n = S_FINISH;
                end
            end
            S_FINISH: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // Timeout reload on every state entry
    always_comb begin
        tmr_load = (state_n != state_q);
        unique case (state_n)
            S_PULL, S_WAIT_CFG, S_WAIT_USER: tmr_val = CNT_W'(STATE_POLLS);
            S_CHECK:                         tmr_val = CNT_W'(CHECK_POLLS);
            S_WAIT_DCLK:                     tmr_val = CNT_W'(DCLK_POLLS);
            default:                         tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            fin_q    <= ST_OK;
            dstat_q  <= ST_OK;
            rst_to_q <= 1'b0;
            wide_q   <= 1'b0;
            ratio_q  <= RATIO_W'(1);
        end else begin
            state_q  <= state_n;
            fin_q    <= fin_n;
            dstat_q  <= dstat_n;
            rst_to_q <= rst_to_n;
            if (latch_mode) begin
                wide_q  <= dec_wide;
                ratio_q <= dec_ratio;
            end
        end
    end

    // Outputs
    always_comb begin
        busy         = (state_q != S_IDLE) && (state_q != S_FINISH);
        done         = (state_q == S_FINISH);
        nce          = !busy;
        nconfig_pull = (state_q == S_PULL);
        nstatus_clr  = (state_q == S_CLR_NS);
        data_en      = (state_q == S_DATA) || (state_q == S_CHECK);
        dclk_load    = (state_q == S_DATA_OFF);
    end

    assign status     = fin_q;
    assign wide_bus   = wide_q;
    assign cd_ratio   = ratio_q;
    assign dclk_count = DCLK_W'(TRAIL_DCLKS);

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       ctl_en,
    input logic       fab_pwr_ok,
    input logic [3:0] msel,
    input logic       busy,
    input logic       done,
    input logic [2:0] status,
    input logic [3:0] cd_ratio,
    input logic       nconfig_pull,
    input logic       nstatus_clr,
    input logic       data_en,
    input logic       dclk_load
);

    // R5
    pull_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nconfig_pull && data_en));

    // R5
    clr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nstatus_clr |=> (data_en && !nstatus_clr));

    // R8
    dclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_load |-> (!data_en ##1 !dclk_load));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> done);

    // R4
    refuse_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && !ctl_en) |=> (done && status == 3'd4));

    // R3
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && ctl_en && fab_pwr_ok &&
         (msel inside {4'd3, 4'd7, 4'd11, 4'd15})) |=> (done && status == 3'd6));

    // R2
    ratio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cd_ratio) == 1);

endmodule

bind fpga_cfg_seq fcs_chk u_fcs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ctl_en       (ctl_en),
    .fab_pwr_ok   (fab_pwr_ok),
    .msel         (msel),
    .busy         (busy),
    .done         (done),
    .status       (status),
    .cd_ratio     (cd_ratio),
    .nconfig_pull (nconfig_pull),
    .nstatus_clr  (nstatus_clr),
    .data_en      (data_en),
    .dclk_load    (dclk_load)
);

// File: tb/fpga_cfg_seq_tb_top.sv
module fpga_cfg_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_MAX   = 12000;

    localparam logic [2:0] E_OK = 3'd0, E_FAIL = 3'd1, E_CRC = 3'd2, E_TMO = 3'd3,
                           E_NOCTL = 3'd4, E_PWR = 3'd5, E_BAD = 3'd6;

    typedef struct packed {
        logic [3:0] code;
        logic       ok;
        logic       w32;
        logic [3:0] ratio;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{4'd0,  1'b1, 1'b0, 4'd1}, '{4'd1,  1'b1, 1'b0, 4'd2},
        '{4'd2,  1'b1, 1'b0, 4'd4}, '{4'd3,  1'b0, 1'b0, 4'd0},
        '{4'd4,  1'b1, 1'b0, 4'd1}, '{4'd5,  1'b1, 1'b0, 4'd2},
        '{4'd6,  1'b1, 1'b0, 4'd4}, '{4'd7,  1'b0, 1'b0, 4'd0},
        '{4'd8,  1'b1, 1'b1, 4'd1}, '{4'd9,  1'b1, 1'b1, 4'd4},
        '{4'd10, 1'b1, 1'b1, 4'd8}, '{4'd11, 1'b0, 1'b0, 4'd0},
        '{4'd12, 1'b1, 1'b1, 4'd1}, '{4'd13, 1'b1, 1'b1, 4'd4},
        '{4'd14, 1'b1, 1'b1, 4'd8}, '{4'd15, 1'b0, 1'b0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, ctl_en = 1'b0, fab_pwr_ok = 1'b0;
    logic [3:0]  msel = 4'd0;
    logic [1:0]  fab_phase = 2'd2;
    logic        conf_done = 1'b0, nstatus = 1'b0, crc_err = 1'b0;
    logic        data_last = 1'b0, data_err = 1'b0, dclk_done = 1'b0;
    logic        busy, done, wide_bus, nce, nconfig_pull, nstatus_clr, data_en, dclk_load;
    logic [2:0]  status;
    logic [3:0]  cd_ratio;
    logic [15:0] dclk_count;

    int checks = 0, failures = 0;

    // fabric model knobs
    bit k_no_reset = 0, k_no_cfg = 0, k_no_user = 0, k_no_dclk = 0, k_data_err = 0;
    int k_result = 0;

    // event stamps
    int cyc = 0, dcnt = 0, dlen = 0;
    bit sent = 0, prev_pull = 0, prev_den = 0, pull_seen = 0;
    int t_pr = 0, t_pf = 0, t_clr = 0, t_don = 0, t_doff = 0, t_load = 0;
    logic nce_at_pull = 1'b1;
    logic [15:0] cnt_at_load = 16'd0;
    int n_wait = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpga_cfg_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ctl_en(ctl_en), .fab_pwr_ok(fab_pwr_ok),
        .msel(msel), .fab_phase(fab_phase), .conf_done(conf_done), .nstatus(nstatus),
        .crc_err(crc_err), .data_last(data_last), .data_err(data_err), .dclk_done(dclk_done),
        .busy(busy), .done(done), .status(status), .wide_bus(wide_bus), .cd_ratio(cd_ratio),
        .nce(nce), .nconfig_pull(nconfig_pull), .nstatus_clr(nstatus_clr), .data_en(data_en),
        .dclk_load(dclk_load), .dclk_count(dclk_count)
    );

    // Fabric, packer and DCLK counter model plus event monitor (negedge)
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (nconfig_pull && !prev_pull) begin t_pr = cyc; nce_at_pull = nce; pull_seen = 1; end
        if (!nconfig_pull && prev_pull) t_pf = cyc;
        if (nstatus_clr) t_clr = cyc;
        if (data_en && !prev_den) t_don = cyc;
        if (!data_en && prev_den) t_doff = cyc;
        prev_pull = nconfig_pull;
        prev_den  = data_en;
        if (nconfig_pull) begin
            if (!k_no_reset) fab_phase = 2'd0;
            conf_done = 0; nstatus = 0; crc_err = 0; dcnt = 0; dlen = 0; sent = 0;
        end else if (fab_phase == 2'd0 && !k_no_cfg) begin
            fab_phase = 2'd1; nstatus = 1;
        end
        data_last = 0; data_err = 0;
        if (data_en && !sent) begin
            dlen = dlen + 1;
            if (dlen == 6) begin
                sent = 1;
                if (k_data_err) data_err = 1;
                else begin
                    data_last = 1;
                    case (k_result)
                        0: begin conf_done = 1; nstatus = 1; end
                        1: begin conf_done = 0; nstatus = 0; end
                        2: crc_err = 1;
                        default: begin conf_done = 1; nstatus = 0; end
                    endcase
                end
            end
        end
        dclk_done = 0;
        if (dclk_load) begin
            t_load = cyc; cnt_at_load = dclk_count; dcnt = int'(dclk_count);
        end else if (dcnt != 0) begin
            dcnt = dcnt - 1;
            if (dcnt == 0 && !k_no_dclk) begin
                dclk_done = 1;
                if (!k_no_user) fab_phase = 2'd3;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic knobs_clear();
        k_no_reset = 0; k_no_cfg = 0; k_no_user = 0; k_no_dclk = 0; k_data_err = 0; k_result = 0;
        fab_phase = 2'd2;
    endtask

    task automatic wait_done();
        n_wait = 0;
        while (!done && n_wait < WAIT_MAX) begin
            @(negedge clk);
            n_wait++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: no done actual=0 expected=1");
        end
    endtask

    task automatic run(input logic [3:0] code, input logic ce, input logic pw);
        @(negedge clk);
        msel = code; ctl_en = ce; fab_pwr_ok = pw;
        pull_seen = 0; t_pr = 0; t_pf = 0; t_clr = 0; t_don = 0; t_doff = 0; t_load = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        wait_done();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL global watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset busy", busy, 0);
        check("R11 reset done", done, 0);
        check("R5 reset nce", nce, 1);
        check("R5 reset pull", nconfig_pull, 0);
        check("R5 reset data_en", data_en, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 R2 R3: decode table walk
        for (int i = 0; i < 16; i++) begin
            knobs_clear();
            run(VECS[i].code, 1'b1, 1'b1);
            if (VECS[i].ok) begin
                check("R1 width", wide_bus, VECS[i].w32);
                check("R2 ratio", cd_ratio, VECS[i].ratio);
                check("R7 pass status", status, E_OK);
            end else begin
                check("R3 bad mode status", status, E_BAD);
                check("R3 no pull", pull_seen, 0);
            end
        end

        // R4: refusals
        knobs_clear();
        run(4'd0, 1'b0, 1'b1);
        check("R4 no control", status, E_NOCTL);
        check("R4 refuse latency", n_wait, 0);
        run(4'd0, 1'b0, 1'b0);
        check("R4 no control wins", status, E_NOCTL);
        run(4'd0, 1'b1, 1'b0);
        check("R4 power off", status, E_PWR);
        check("R4 power latency", n_wait, 0);

        // R5 R8 R11: ordering on a good run
        knobs_clear();
        run(4'd9, 1'b1, 1'b1);
        check("R5 nce low at pull", nce_at_pull, 0);
        check("R5 pull before release", int'(t_pr < t_pf), 1);
        check("R5 release before clear", int'(t_pf < t_clr), 1);
        check("R5 clear before data", int'(t_clr < t_don), 1);
        check("R8 data off at load", int'(t_doff == t_load && t_load > t_don), 1);
        check("R8 dclk count", cnt_at_load, 4);
        check("R11 busy low at done", busy, 0);
        check("R7 pass", status, E_OK);

        // R7: failure and CRC
        knobs_clear(); k_result = 1;
        run(4'd1, 1'b1, 1'b1);
        check("R7 cfg fail", status, E_FAIL);
        knobs_clear(); k_result = 2;
        run(4'd2, 1'b1, 1'b1);
        check("R7 crc", status, E_CRC);

        // R6: reset-phase timeout
        knobs_clear(); k_no_reset = 1;
        run(4'd0, 1'b1, 1'b1);
        check("R6 status", status, E_TMO);
        check("R6 pull released", nconfig_pull, 0);
        check("R6 released before done", int'(t_pf > 0), 1);
        check("R6 poll window", int'(n_wait >= 2048 && n_wait <= 2060), 1);

        // R9: config-phase, check and DCLK timeouts
        knobs_clear(); k_no_cfg = 1;
        run(4'd0, 1'b1, 1'b1);
        check("R9 cfg phase timeout", status, E_TMO);
        check("R9 cfg window", int'(n_wait >= 2048 && n_wait <= 2070), 1);
        knobs_clear(); k_result = 3;
        run(4'd0, 1'b1, 1'b1);
        check("R9 check timeout", status, E_TMO);
        check("R9 check window", int'(n_wait >= 8192 && n_wait <= 8230), 1);
        knobs_clear(); k_no_dclk = 1;
        run(4'd0, 1'b1, 1'b1);
        check("R9 dclk timeout", status, E_TMO);
        check("R9 dclk window", int'(n_wait >= 2056 && n_wait <= 2090), 1);
        knobs_clear(); k_no_user = 1;
        run(4'd0, 1'b1, 1'b1);
        check("R9 user timeout", status, E_TMO);

        // R10: data-phase fault wins
        knobs_clear(); k_data_err = 1;
        run(4'd0, 1'b1, 1'b1);
        check("R10 data fault", status, E_FAIL);
        knobs_clear(); k_data_err = 1; k_no_user = 1;
        run(4'd0, 1'b1, 1'b1);
        check("R10 precedence over timeout", status, E_FAIL);

        // R12: start while busy ignored
        knobs_clear();
        @(negedge clk);
        msel = 4'd0; ctl_en = 1; fab_pwr_ok = 1; start = 1;
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        check("R11 busy during run", busy, 1);
        ctl_en = 0; start = 1;
        @(negedge clk); start = 0;
        wait_done();
        check("R12 ignored start status", status, E_OK);
        begin
            int extra = 0;
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            check("R12 no second run", extra, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule